// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides when an analog-to-digital converter starts a conversion while automatic triggering is switched on. It owns one 8-bit control register. A 4-bit select field in that register picks one of sixteen trigger sources. Two further bits hold static enables for an analog current source and for connecting the reference pin. The analog circuits themselves lie outside this block, so the two enables are only stored and driven out.

Event input `k` belongs to select code `k`. Most sources are interrupt-style flags, which trigger on their rising edge. Three sources are synchronization strobes from PWM stages; these have no flag and trigger whenever they are present while the converter is idle. Code zero runs the converter continuously. The block sends a one-cycle start pulse to the conversion sequencer, which reports back through busy and done status lines.

Top module: `adc_trig_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register is cleared to 0x00, all edge history is forgotten and `soc_o` is low after that edge.
- R2: A write stores bits 7, 6, 5 and 3..0 of `reg_wr_data`, and the new value reads back on `reg_rd_data` from the next cycle. Bit 4 always reads 0. Bit 6 drives `isrc_en_o` and bit 5 drives `refpin_en_o`.
- R3: While `auto_en` is low, `soc_o` never rises, whatever the select code and the events.
- R4: Select field (bits 3..0) decoding: code 0 is free-running. Codes 1–6 and 10–13 are flag sources. Codes 7, 8 and 9 are flagless synchronization sources. Codes 14 and 15 are reserved. Code k watches `evt_i[k]`.
- R5: For a flag source, `evt_i[sel]` high in a cycle after it was low in the previous cycle gives exactly one `soc_o` pulse in the following cycle. A flag that is held high does not trigger again.
- R6: A flag edge that arrives while `conv_busy` is high, or while `soc_o` is high, is dropped and is not queued.
- R7: For a synchronization source, every cycle in which `evt_i[sel]` is high while `conv_busy` and `soc_o` are both low gives a `soc_o` pulse in the next cycle. Events that arrive while busy are ignored.
- R8: In free-running mode, `soc_o` pulses in the cycle after `conv_done` is high. It also pulses once after `auto_en` rises while `conv_busy` is low.
- R9: Reserved codes 14 and 15 never produce `soc_o`.
- R10: A write that changes the select field blanks edge detection for the following cycle. A newly selected source that is already high, or that rises in that cycle, does not trigger.
- R11: `soc_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| reg_rd_data | output | 8 | Control register read value |
| auto_en | input | 1 | Automatic trigger enable |
| evt_i | input | 16 | Candidate trigger events, bit k for code k |
| conv_busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | Conversion complete indication |
| soc_o | output | 1 | Start-of-conversion pulse |
| isrc_en_o | output | 1 | Stored current-source enable |
| refpin_en_o | output | 1 | Stored reference-pin enable |

## Verification
The bench builds the block with its default parameters: a 4-bit select field, sixteen event lines, synchronization codes 7 to 9 and reserved codes from 14 up. With these values every code, including both reserved ones and the boundaries between the flag and synchronization groups, can be driven in a single sweep. A behavioural model predicts `soc_o` and the register read-back each cycle. The stimulus covers busy windows, held flags, repeated synchronization strobes, free-running done chains and select changes onto sources that are already high.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        KIND_FREE = 2'd0,
        KIND_FLAG = 2'd1,
        KIND_SYNC = 2'd2,
        KIND_NONE = 2'd3
    } src_kind_e;

    function automatic src_kind_e classify_src(input int code, input int sync_lo,
                                               input int sync_hi, input int rsv_lo);
        if (code == 0)                              return KIND_FREE;
        else if (code >= rsv_lo)                    return KIND_NONE;
        else if (code >= sync_lo && code <= sync_hi) return KIND_SYNC;
        else                                        return KIND_FLAG;
    endfunction

endpackage

// File: rtl/trig_ctrl_reg.sv
module trig_ctrl_reg #(
    parameter int SEL_W = 4,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [SEL_W-1:0] sel_o,
    output logic             isrc_o,
    output logic             refpin_o,
    output logic             sel_chg_o
);
    localparam int RSV_BIT  = REG_W - 4;
    localparam int REF_BIT  = REG_W - 3;
    localparam int ISRC_BIT = REG_W - 2;
    localparam int SPR_BIT  = REG_W - 1;

    typedef struct packed {
        logic             spare;
        logic             isrc;
        logic             refpin;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  unused_rsv;

    assign unused_rsv = wr_data[RSV_BIT];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.spare  = wr_data[SPR_BIT];
            ctrl_d.isrc   = wr_data[ISRC_BIT];
            ctrl_d.refpin = wr_data[REF_BIT];
            ctrl_d.sel    = wr_data[SEL_W-1:0];
        end
        if (!rst_n) ctrl_d = '0;
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rd_data              = '0;
        rd_data[SPR_BIT]     = ctrl_q.spare;
        rd_data[ISRC_BIT]    = ctrl_q.isrc;
        rd_data[REF_BIT]     = ctrl_q.refpin;
        rd_data[SEL_W-1:0]   = ctrl_q.sel;
    end

    assign sel_o     = ctrl_q.sel;
    assign isrc_o    = ctrl_q.isrc;
    assign refpin_o  = ctrl_q.refpin;
    assign sel_chg_o = wr_en && (wr_data[SEL_W-1:0] != ctrl_q.sel);

    // Read-back of the last write, reserved bit forced low (R2)
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == ($past(wr_data) & ~(REG_W'(1) << RSV_BIT))));

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] hist;
        logic         vld;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d.hist = evt_i;
        e_d.vld  = !clr_i;
        if (!rst_n) e_d = '0;
    end

    always_ff @(posedge clk) begin
        e_q <= e_d;
    end

    assign rise_o = evt_i & ~e_q.hist & {N{e_q.vld}};

    // Edge history blanks detection right after a select change (R10)
    assert_blank_after_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rise_o == '0));

endmodule

// File: rtl/trig_soc_fsm.sv
module trig_soc_fsm
    import adc_trig_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int N       = 16,
    parameter int SYNC_LO = 7,
    parameter int SYNC_HI = 9,
    parameter int RSV_LO  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N-1:0]     evt_i,
    input  logic [N-1:0]     rise_i,
    input  logic             conv_busy,
    input  logic             conv_done,
    output logic             soc_o
);
    typedef struct packed {
        logic soc;
        logic auto_seen;
    } fsm_t;

    fsm_t      s_d, s_q;
    src_kind_e kind;
    logic      idle;
    logic      fire;

    always_comb begin
        kind = classify_src(int'(sel_i), SYNC_LO, SYNC_HI, RSV_LO);
        idle = !conv_busy && !s_q.soc;
        fire = 1'b0;
        case (kind)
            KIND_FREE: fire = (conv_done || (!s_q.auto_seen && !conv_busy)) && !s_q.soc;
            KIND_FLAG: fire = rise_i[sel_i] && idle;
            KIND_SYNC: fire = evt_i[sel_i] && idle;
            default:   fire = 1'b0;
        endcase
        s_d.soc       = auto_en && fire;
        s_d.auto_seen = auto_en;
        if (!rst_n) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign soc_o = s_q.soc;

    // A flag or sync source cannot start while busy (R6)
    assert_drop_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && kind != KIND_FREE) |=> !soc_o);

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
    parameter int SEL_W   = 4,
    parameter int REG_W   = 8,
    parameter int SYNC_LO = 7,
    parameter int SYNC_HI = 9,
    parameter int RSV_LO  = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_W-1:0]      reg_wr_data,
    output logic [REG_W-1:0]      reg_rd_data,
    input  logic                  auto_en,
    input  logic [(1<<SEL_W)-1:0] evt_i,
    input  logic                  conv_busy,
    input  logic                  conv_done,
    output logic                  soc_o,
    output logic                  isrc_en_o,
    output logic                  refpin_en_o
);
    localparam int N_SRC = 1 << SEL_W;

    logic [SEL_W-1:0] sel;
    logic             sel_chg;
    logic [N_SRC-1:0] rise;

    trig_ctrl_reg #(.SEL_W(SEL_W), .REG_W(REG_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .rd_data   (reg_rd_data),
        .sel_o     (sel),
        .isrc_o    (isrc_en_o),
        .refpin_o  (refpin_en_o),
        .sel_chg_o (sel_chg)
    );

    trig_edge_det #(.N(N_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (sel_chg),
        .rise_o (rise)
    );

    trig_soc_fsm #(
        .SEL_W   (SEL_W),
        .N       (N_SRC),
        .SYNC_LO (SYNC_LO),
        .SYNC_HI (SYNC_HI),
        .RSV_LO  (RSV_LO)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .sel_i     (sel),
        .evt_i     (evt_i),
        .rise_i    (rise),
        .conv_busy (conv_busy),
        .conv_done (conv_done),
        .soc_o     (soc_o)
    );

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!soc_o && reg_rd_data == '0));

    assert_gated_by_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !soc_o);

    assert_reserved_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) >= RSV_LO) |=> !soc_o);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soc_o |=> !soc_o);

endmodule

// File: tb/tb_adc_trig_sel.sv
module tb_adc_trig_sel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_data = 8'h00;
    logic [7:0]  reg_rd_data;
    logic        auto_en = 1'b0;
    logic [15:0] evt_i = 16'h0000;
    logic        conv_busy = 1'b0;
    logic        conv_done = 1'b0;
    logic        soc_o;
    logic        isrc_en_o;
    logic        refpin_en_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // behavioural reference state
    int          m_ctrl = 0;
    logic [15:0] m_hist = '0;
    bit          m_vld = 0;
    bit          m_auto = 0;
    bit          m_soc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_trig_sel dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .auto_en     (auto_en),
        .evt_i       (evt_i),
        .conv_busy   (conv_busy),
        .conv_done   (conv_done),
        .soc_o       (soc_o),
        .isrc_en_o   (isrc_en_o),
        .refpin_en_o (refpin_en_o)
    );

    task automatic compare(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    // predict from current inputs, advance one clock, compare away from the edge
    task automatic tick();
        int  sel;
        bit  fire;
        bit  idle;
        bit  nsoc;
        sel  = m_ctrl & 15;
        idle = !conv_busy && !m_soc;
        fire = 0;
        if (sel == 0)
            fire = (conv_done || (!m_auto && !conv_busy)) && !m_soc;
        else if (sel >= 14)
            fire = 0;
        else if (sel >= 7 && sel <= 9)
            fire = evt_i[sel] && idle;
        else
            fire = evt_i[sel] && !m_hist[sel] && m_vld && idle;
        nsoc = auto_en && fire;
        @(posedge clk);
        if (!rst_n) begin
            m_ctrl = 0; m_hist = '0; m_vld = 0; m_auto = 0; m_soc = 0;
        end else begin
            m_vld  = !(reg_wr_en && (int'(reg_wr_data[3:0]) != sel));
            m_hist = evt_i;
            m_auto = auto_en;
            m_soc  = nsoc;
            if (reg_wr_en) m_ctrl = int'(reg_wr_data) & 8'hEF;
        end
        @(negedge clk);
        compare("soc_o", int'(soc_o), int'(m_soc));
        compare("reg_rd_data", int'(reg_rd_data), m_ctrl);
        compare("isrc_en_o", int'(isrc_en_o), (m_ctrl >> 6) & 1);
        compare("refpin_en_o", int'(refpin_en_o), (m_ctrl >> 5) & 1);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_reg(input logic [7:0] v);
        reg_wr_en = 1'b1; reg_wr_data = v;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        ticks(3);
        rst_n = 1'b1;
        tick();

        // R2: register storage, reserved bit, enable outputs
        cur_req = "R2";
        write_reg(8'hFF);
        ticks(2);
        write_reg(8'h40);
        tick();
        write_reg(8'hA0);
        tick();

        // R3: auto-trigger off, flag rise has no effect on soc_o
        cur_req = "R3";
        write_reg(8'h01);
        tick();
        evt_i[1] = 1'b1; ticks(2);
        evt_i = '0; tick();
        write_reg(8'h08);
        evt_i[8] = 1'b1; ticks(3);
        evt_i = '0; tick();

        // R4 R5 R7 R8 R9: sweep every code with a rising event
        for (int code = 0; code < 16; code++) begin
            cur_req = (code >= 14) ? "R9" : "R4";
            auto_en = 1'b0; evt_i = '0;
            write_reg(8'(code));
            ticks(2);
            auto_en = 1'b1; tick();
            tick();
            cur_req = (code >= 14) ? "R9" : "R5";
            evt_i[code] = 1'b1; ticks(3);
            evt_i = '0; tick();
            evt_i = 16'hFFFF; ticks(2);
            evt_i = '0; ticks(2);
        end
        auto_en = 1'b0; tick();

        // R6: flag edge while busy is dropped
        cur_req = "R6";
        write_reg(8'h02);
        auto_en = 1'b1; tick();
        conv_busy = 1'b1; tick();
        evt_i[2] = 1'b1; ticks(2);
        conv_busy = 1'b0; ticks(3);
        evt_i = '0; tick();
        evt_i[2] = 1'b1; tick();
        evt_i[2] = 1'b0; tick();
        evt_i[2] = 1'b1; tick();
        evt_i = '0; ticks(2);

        // R7: synchronization strobes fire only when idle
        cur_req = "R7";
        write_reg(8'h08);
        tick();
        conv_busy = 1'b1;
        evt_i[8] = 1'b1; tick();
        evt_i = '0; ticks(2);
        conv_busy = 1'b0;
        for (int k = 0; k < 4; k++) begin
            evt_i[8] = 1'b1; tick();
            evt_i = '0; ticks(2);
        end
        evt_i[9] = 1'b1; ticks(2);
        evt_i = '0; tick();
        evt_i[8] = 1'b1; ticks(4);
        evt_i = '0; tick();

        // R8: free-running mode
        cur_req = "R8";
        auto_en = 1'b0;
        write_reg(8'h00);
        tick();
        auto_en = 1'b1; tick();
        for (int k = 0; k < 3; k++) begin
            conv_busy = 1'b1; ticks(3);
            conv_busy = 1'b0; conv_done = 1'b1; tick();
            conv_done = 1'b0; ticks(2);
        end
        auto_en = 1'b0; tick();
        conv_busy = 1'b1; auto_en = 1'b1; ticks(2);
        conv_busy = 1'b0; conv_done = 1'b1; tick();
        conv_done = 1'b0; ticks(2);

        // R9: reserved codes with all events toggling
        cur_req = "R9";
        write_reg(8'h0F);
        for (int k = 0; k < 3; k++) begin
            evt_i = 16'hFFFF; tick();
            evt_i = '0; tick();
        end
        conv_done = 1'b1; tick();
        conv_done = 1'b0; tick();

        // R10: switching select onto a high or rising source
        cur_req = "R10";
        write_reg(8'h01);
        tick();
        evt_i[3] = 1'b1; ticks(2);
        write_reg(8'h03);
        ticks(3);
        evt_i = '0;
        write_reg(8'h05);
        evt_i[5] = 1'b1; ticks(3);
        evt_i = '0; tick();
        evt_i[5] = 1'b1; tick();
        evt_i = '0; ticks(2);

        // R11: back-to-back stimuli never give two adjacent pulses
        cur_req = "R11";
        write_reg(8'h07);
        evt_i[7] = 1'b1; ticks(6);
        evt_i = '0;
        write_reg(8'h00);
        conv_done = 1'b1; ticks(4);
        conv_done = 1'b0; ticks(2);

        // R1: reset mid-operation
        cur_req = "R1";
        write_reg(8'hE9);
        rst_n = 1'b0; ticks(2);
        rst_n = 1'b1; ticks(2);

        finish_run();
    end
endmodule